// File: doc/BRIEF.md
# Pipelined Radix-4 Integer Multiplier

This block multiplies two 32-bit integers and returns one 32-bit half of the 64-bit product. It covers the four multiply variants of the RISC-V M extension. Each operand is widened to 34 bits, with sign or zero extension as the operation requires. A single signed radix-4 Booth recoder then turns the multiplier into 17 digits in the range -2..+2. The resulting partial products, together with one row of negation correction bits, are summed by a tree of 4:2 compressors. The last two rows go through a single carry-propagate adder.

The tree is cut by one pipeline register, and the output is registered. A result is therefore due a fixed two cycles after its operands, and a new operation may enter on every cycle. A destination tag travels with each operation and comes back next to the result under a valid strobe. A flush input drops every operation still in flight. The block has no stall or back-pressure, so the consumer must take each result in the cycle it appears.

Top module: `mul_r4_top`

## Requirements
- R1: With `op_i` = 0 (low product), `result_o` equals the low 32 bits of `rs1_i * rs2_i`.
- R2: With `op_i` = 1 (high, signed by signed), `result_o` equals bits 63:32 of the product, with both operands read as two's complement.
- R3: With `op_i` = 2 (high, signed by unsigned), `result_o` equals bits 63:32 of the product, with `rs1_i` signed and `rs2_i` unsigned.
- R4: With `op_i` = 3 (high, unsigned by unsigned), `result_o` equals bits 63:32 of the product, with both operands unsigned.
- R5: An operation presented with `valid_i` high in cycle t and no flush in cycles t or t+1 gives `valid_o` high in cycle t+2 only, with its result.
- R6: Operations may be presented on consecutive cycles. Each one returns in order, one per cycle, with no gap.
- R7: `tag_o` equals the `tag_i` that was presented with the operation whose result is on `result_o`.
- R8: A high `flush_i` in cycle t cancels every operation presented in cycles t-1 and t, so `valid_o` stays low in cycles t+1 and t+2 for those operations.
- R9: While `rst_ni` is low, and in the first cycle after it goes high, `valid_o` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| flush_i | input | 1 | Cancel all operations in flight |
| valid_i | input | 1 | Operation present on the inputs |
| op_i | input | 2 | Variant: 0 low, 1 high s*s, 2 high s*u, 3 high u*u |
| rs1_i | input | 32 | First operand |
| rs2_i | input | 32 | Second operand |
| tag_i | input | TAG_W (6) | Destination tag |
| valid_o | output | 1 | Result present |
| tag_o | output | TAG_W (6) | Tag of the returned operation |
| result_o | output | 32 | Selected product half |

## Verification
Every result is due exactly two clock edges after its operands are sampled. The bench drives inputs on the falling edge and keeps its own two-slot expectation pipe, advanced on the rising edge. On every falling edge it compares `valid_o`, `tag_o` and `result_o` against the slot that has had two edges to age. A dedicated latency test also samples the cycle before the result is due and requires `valid_o` to be low there. The flush test checks the two cycles after a flush and requires that nothing cancelled comes out in either of them.

// File: rtl/mul_r4_pkg.sv
package mul_r4_pkg;
  localparam int XLEN   = 32;
  localparam int EXT_W  = XLEN + 2;
  localparam int PROD_W = 2 * XLEN;
  localparam int N_PP   = EXT_W / 2;
  localparam int N_ROWS = N_PP + 1;

  typedef enum logic [1:0] {
    OP_LO    = 2'd0,
    OP_HI_SS = 2'd1,
    OP_HI_SU = 2'd2,
    OP_HI_UU = 2'd3
  } mul_op_e;

  // rows left after lv levels of 4:2 reduction
  function automatic int rows_after(input int n, input int lv);
    int r;
    r = n;
    for (int i = 0; i < lv; i++) r = 2 * (r / 4) + (r % 4);
    return r;
  endfunction

  function automatic int levels_to_two(input int n);
    int r;
    int lv;
    r = n;
    lv = 0;
    while (r > 2) begin
      r = 2 * (r / 4) + (r % 4);
      lv++;
    end
    return lv;
  endfunction
endpackage

// File: rtl/mul_cmp42.sv
module mul_cmp42 #(
  parameter int W = 64
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic [W-1:0] c_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] sum_o,
  output logic [W-1:0] carry_o
);
  logic [W-1:0] s1, c1, cin;

  assign s1      = a_i ^ b_i ^ c_i;
  assign c1      = (a_i & b_i) | (a_i & c_i) | (b_i & c_i);
  assign cin     = {c1[W-2:0], 1'b0};
  assign sum_o   = s1 ^ d_i ^ cin;
  assign carry_o = {((s1[W-2:0] & d_i[W-2:0]) | (s1[W-2:0] & cin[W-2:0]) |
                     (d_i[W-2:0] & cin[W-2:0])), 1'b0};
endmodule

// File: rtl/mul_cmp_tree.sv
module mul_cmp_tree
  import mul_r4_pkg::*;
#(
  parameter int W     = 64,
  parameter int N_IN  = 18,
  parameter int N_LVL = 2,
  parameter int N_OUT = rows_after(N_IN, N_LVL)
) (
  input  logic [W-1:0] rows_i [N_IN],
  output logic [W-1:0] rows_o [N_OUT]
);
  for (genvar l = 0; l <= N_LVL; l++) begin : g_lvl
    localparam int NR = rows_after(N_IN, l);
    logic [W-1:0] r [NR];
    if (l == 0) begin : g_in
      for (genvar k = 0; k < NR; k++) begin : g_cp
        assign r[k] = rows_i[k];
      end
    end else begin : g_red
      localparam int NP = rows_after(N_IN, l - 1);
      localparam int NG = NP / 4;
      for (genvar g = 0; g < NG; g++) begin : g_c
        mul_cmp42 #(.W(W)) u_c (
          .a_i    (g_lvl[l-1].r[4*g]),
          .b_i    (g_lvl[l-1].r[4*g+1]),
          .c_i    (g_lvl[l-1].r[4*g+2]),
          .d_i    (g_lvl[l-1].r[4*g+3]),
          .sum_o  (r[2*g]),
          .carry_o(r[2*g+1])
        );
      end
      for (genvar k = 0; k < NP % 4; k++) begin : g_pass
        assign r[2*NG+k] = g_lvl[l-1].r[4*NG+k];
      end
    end
  end

  for (genvar k = 0; k < N_OUT; k++) begin : g_out
    assign rows_o[k] = g_lvl[N_LVL].r[k];
  end
endmodule

// File: rtl/mul_booth_pp.sv
module mul_booth_pp
  import mul_r4_pkg::*;
(
  input  logic [EXT_W-1:0]  a_i,
  input  logic [EXT_W-1:0]  b_i,
  output logic [PROD_W-1:0] rows_o [N_ROWS]
);
  logic [PROD_W-1:0] a_sx;
  logic [N_PP-1:0]   neg;

  assign a_sx = {{(PROD_W-EXT_W){a_i[EXT_W-1]}}, a_i};

  for (genvar i = 0; i < N_PP; i++) begin : g_pp
    logic [2:0]        trip;
    logic              one, two;
    logic [PROD_W-1:0] mag, sel;

    if (i == 0) begin : g_lsb
      assign trip = {b_i[1], b_i[0], 1'b0};
    end else begin : g_mid
      assign trip = b_i[2*i+1:2*i-1];
    end

    assign one    = trip[0] ^ trip[1];
    assign two    = (trip == 3'b011) || (trip == 3'b100);
    assign neg[i] = trip[2] & ~(trip[1] & trip[0]);
    assign mag    = one ? a_sx : (two ? {a_sx[PROD_W-2:0], 1'b0} : '0);
    assign sel    = neg[i] ? ~mag : mag;
    // -(m*4^i) = (~m)*4^i + 4^i ; the +4^i goes into the correction row
    assign rows_o[i] = sel << (2 * i);
  end

  always_comb begin
    rows_o[N_PP] = '0;
    for (int i = 0; i < N_PP; i++) rows_o[N_PP][2*i] = neg[i];
  end
endmodule

// File: rtl/mul_r4_top.sv
module mul_r4_top
  import mul_r4_pkg::*;
#(
  parameter int TAG_W    = 6,
  parameter int ST1_LVLS = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             flush_i,
  input  logic             valid_i,
  input  logic [1:0]       op_i,
  input  logic [XLEN-1:0]  rs1_i,
  input  logic [XLEN-1:0]  rs2_i,
  input  logic [TAG_W-1:0] tag_i,
  output logic             valid_o,
  output logic [TAG_W-1:0] tag_o,
  output logic [XLEN-1:0]  result_o
);
  localparam int TOT_LVLS = levels_to_two(N_ROWS);
  localparam int ST2_LVLS = TOT_LVLS - ST1_LVLS;
  localparam int N_MID    = rows_after(N_ROWS, ST1_LVLS);

  mul_op_e          op;
  logic             a_sgn, b_sgn;
  logic [EXT_W-1:0] a_ext, b_ext;

  assign op    = mul_op_e'(op_i);
  assign a_sgn = (op != OP_HI_UU);
  assign b_sgn = (op == OP_LO) || (op == OP_HI_SS);
  assign a_ext = {{2{a_sgn & rs1_i[XLEN-1]}}, rs1_i};
  assign b_ext = {{2{b_sgn & rs2_i[XLEN-1]}}, rs2_i};

  logic [PROD_W-1:0] pp_rows  [N_ROWS];
  logic [PROD_W-1:0] mid_rows [N_MID];
  logic [PROD_W-1:0] mid_q    [N_MID];
  logic [PROD_W-1:0] fin_rows [2];

  mul_booth_pp u_pp (
    .a_i   (a_ext),
    .b_i   (b_ext),
    .rows_o(pp_rows)
  );

  mul_cmp_tree #(.W(PROD_W), .N_IN(N_ROWS), .N_LVL(ST1_LVLS)) u_tree1 (
    .rows_i(pp_rows),
    .rows_o(mid_rows)
  );

  // stage 1 register
  logic             s1_vld_q;
  mul_op_e          s1_op_q;
  logic [TAG_W-1:0] s1_tag_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) s1_vld_q <= 1'b0;
    else         s1_vld_q <= valid_i & ~flush_i;
  end

  always_ff @(posedge clk_i) begin
    s1_op_q  <= op;
    s1_tag_q <= tag_i;
    for (int k = 0; k < N_MID; k++) mid_q[k] <= mid_rows[k];
  end

  mul_cmp_tree #(.W(PROD_W), .N_IN(N_MID), .N_LVL(ST2_LVLS)) u_tree2 (
    .rows_i(mid_q),
    .rows_o(fin_rows)
  );

  logic [PROD_W-1:0] prod;
  logic [XLEN-1:0]   res_d;

  assign prod  = fin_rows[0] + fin_rows[1];
  assign res_d = (s1_op_q == OP_LO) ? prod[XLEN-1:0] : prod[PROD_W-1:XLEN];

  // output register
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) valid_o <= 1'b0;
    else         valid_o <= s1_vld_q & ~flush_i;
  end

  always_ff @(posedge clk_i) begin
    tag_o    <= s1_tag_q;
    result_o <= res_d;
  end

  a_r5_accept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !flush_i) |=> s1_vld_q);
  a_r5_out_has_source: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> $past(s1_vld_q));
  a_r8_flush_stage: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> !s1_vld_q);
  a_r8_flush_out: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> !valid_o);
  a_r7_tag_follow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (s1_vld_q && !flush_i) |=> (tag_o == $past(s1_tag_q)));
endmodule

// File: tb/test_mul_r4_top.sv
`timescale 1ns/1ps
module test_mul_r4_top;
  localparam int TAG_W = 6;

  logic             clk = 1'b0;
  logic             rst_ni = 1'b0;
  logic             flush_i = 1'b0;
  logic             valid_i = 1'b0;
  logic [1:0]       op_i = '0;
  logic [31:0]      rs1_i = '0;
  logic [31:0]      rs2_i = '0;
  logic [TAG_W-1:0] tag_i = '0;
  logic             valid_o;
  logic [TAG_W-1:0] tag_o;
  logic [31:0]      result_o;

  int n_chk = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  mul_r4_top #(.TAG_W(TAG_W)) i_mul_r4_top (
    .clk_i(clk), .rst_ni(rst_ni), .flush_i(flush_i), .valid_i(valid_i),
    .op_i(op_i), .rs1_i(rs1_i), .rs2_i(rs2_i), .tag_i(tag_i),
    .valid_o(valid_o), .tag_o(tag_o), .result_o(result_o)
  );

  function automatic logic [31:0] ref_res(logic [1:0] op, logic [31:0] a, logic [31:0] b);
    logic [63:0] ax, bx, p;
    ax = (op == 2'd3) ? {32'd0, a} : {{32{a[31]}}, a};
    bx = (op == 2'd2 || op == 2'd3) ? {32'd0, b} : {{32{b[31]}}, b};
    p  = ax * bx;
    return (op == 2'd0) ? p[31:0] : p[63:32];
  endfunction

  function automatic string req_of(logic [1:0] op);
    case (op)
      2'd0: return "R1";
      2'd1: return "R2";
      2'd2: return "R3";
      default: return "R4";
    endcase
  endfunction

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h @%0t", req, act, exp, $time);
    end
  endtask

  // expectation pipe: slot 1 after one edge, slot 2 after two
  logic        e1_v = 1'b0, e2_v = 1'b0;
  logic [31:0] e1_r, e2_r;
  logic [TAG_W-1:0] e1_t, e2_t;
  logic [1:0]  e1_o, e2_o;
  logic        mon_en = 1'b0;

  always @(posedge clk) begin
    if (!rst_ni || flush_i) begin
      e1_v <= 1'b0;
      e2_v <= 1'b0;
    end else begin
      e1_v <= valid_i;
      e1_r <= ref_res(op_i, rs1_i, rs2_i);
      e1_t <= tag_i;
      e1_o <= op_i;
      e2_v <= e1_v;
      e2_r <= e1_r;
      e2_t <= e1_t;
      e2_o <= e1_o;
    end
  end

  always @(negedge clk) begin
    if (mon_en) begin
      check("R5 valid", {63'd0, valid_o}, {63'd0, e2_v});
      if (e2_v && valid_o) begin
        check(req_of(e2_o), {32'd0, result_o}, {32'd0, e2_r});
        check("R7 tag", {58'd0, tag_o}, {58'd0, e2_t});
      end
    end
  end

  task automatic drive(logic [1:0] op, logic [31:0] a, logic [31:0] b, logic [TAG_W-1:0] t);
    valid_i = 1'b1; op_i = op; rs1_i = a; rs2_i = b; tag_i = t;
    @(negedge clk);
  endtask

  task automatic idle(int n);
    valid_i = 1'b0;
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic t_reset;
    @(negedge clk);
    check("R9 in reset", {63'd0, valid_o}, 64'd0);
    rst_ni = 1'b1;
    @(negedge clk);
    check("R9 after release", {63'd0, valid_o}, 64'd0);
    mon_en = 1'b1;
  endtask

  task automatic t_low;
    drive(2'd0, 32'd7, 32'd9, 6'd1);
    drive(2'd0, 32'hFFFF_FFFF, 32'd3, 6'd2);
    drive(2'd0, 32'h1234_5678, 32'h9ABC_DEF0, 6'd3);
    drive(2'd0, 32'h8000_0000, 32'h8000_0000, 6'd4);
    idle(3);
  endtask

  task automatic t_hi_ss;
    drive(2'd1, 32'h8000_0000, 32'h8000_0000, 6'd5);
    drive(2'd1, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 6'd6);
    drive(2'd1, 32'h7FFF_FFFF, 32'h8000_0000, 6'd7);
    drive(2'd1, 32'h1234_5678, 32'hF000_0001, 6'd8);
    idle(3);
  endtask

  task automatic t_hi_su;
    drive(2'd2, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 6'd9);
    drive(2'd2, 32'h8000_0000, 32'hFFFF_FFFF, 6'd10);
    drive(2'd2, 32'h7FFF_FFFF, 32'h8000_0000, 6'd11);
    idle(3);
  endtask

  task automatic t_hi_uu;
    drive(2'd3, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 6'd12);
    drive(2'd3, 32'h8000_0000, 32'h0000_0002, 6'd13);
    drive(2'd3, 32'hDEAD_BEEF, 32'hCAFE_F00D, 6'd14);
    idle(3);
  endtask

  task automatic t_latency;
    drive(2'd3, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 6'd21);
    valid_i = 1'b0;
    check("R5 not early", {63'd0, valid_o}, 64'd0);
    @(negedge clk);
    check("R5 due", {63'd0, valid_o}, 64'd1);
    check("R4 value", {32'd0, result_o}, 64'h0000_0000_FFFF_FFFE);
    check("R7 tag", {58'd0, tag_o}, 64'd21);
    @(negedge clk);
    check("R5 single strobe", {63'd0, valid_o}, 64'd0);
    idle(1);
  endtask

  task automatic t_b2b;
    logic [31:0] s;
    s = 32'hACE1_2345;
    for (int i = 0; i < 24; i++) begin
      s = {s[30:0], s[31] ^ s[21] ^ s[1] ^ s[0]};
      drive(i[1:0], s, {s[15:0], s[31:16]} ^ 32'h5A5A_0F0F, TAG_W'(i + 30));
    end
    idle(1);
    check("R6 stream tail", {63'd0, valid_o}, 64'd1);
    idle(3);
  endtask

  task automatic t_flush;
    drive(2'd0, 32'd3, 32'd5, 6'd40);
    valid_i = 1'b1; op_i = 2'd1; rs1_i = 32'd6; rs2_i = 32'd7; tag_i = 6'd41;
    flush_i = 1'b1;
    @(negedge clk);
    flush_i = 1'b0;
    valid_i = 1'b0;
    check("R8 cycle1", {63'd0, valid_o}, 64'd0);
    @(negedge clk);
    check("R8 cycle2", {63'd0, valid_o}, 64'd0);
    drive(2'd0, 32'd11, 32'd13, 6'd42);
    idle(1);
    check("R8 resume", {63'd0, valid_o}, 64'd1);
    check("R8 resume value", {32'd0, result_o}, 64'd143);
    idle(2);
  endtask

  initial begin
    t_reset();
    t_low();
    t_hi_ss();
    t_hi_su();
    t_hi_uu();
    t_latency();
    t_b2b();
    t_flush();
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule